// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block decides how a newly raised processor fault is handled in a small exception model. A fault request names one of four kinds: memory-management, bus, usage or hard. The block weighs that kind against the handler-enable bits, the programmable priorities of the three configurable kinds, and the current execution context and priority. From these it picks one outcome. The fault is either taken as its own kind or escalated to a hard fault, and the outcome says whether the chosen handler preempts the current code.

A hard fault raised while the hard fault handler or the NMI handler is running cannot be serviced. In that case the block enters a lockup state and holds instruction execution halted. An NMI ends the lockup, unless the lockup began inside the NMI handler; then only reset ends it. The block also keeps a sticky status bit for each fault kind, plus a flag that marks a hard fault as forced by escalation. Software clears these bits by writing one to them.

Fault requests use a valid/ready handshake. `req_ready` is low only while the block is locked up, and requests offered then are dropped. The outcome comes out as a single-cycle pulse on `out_valid` with no back-pressure: a consumer must take it in the cycle it appears.

Top module: `fault_esc_ctrl`

## Requirements
- R1: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives its outcome on `out_valid`, `out_kind`, `out_escalated` and `out_preempt` from that same edge. `out_valid` is high for exactly one cycle. `req_ready` is low while locked, and a request offered then produces no outcome and no status change.
- R2: A memory-management (kind 0), bus (kind 1) or usage (kind 2) fault whose handler-enable bit is clear is taken as a hard fault (kind 3) with `out_escalated` high.
- R3: A configurable fault raised while the handler of the same kind is running escalates to hard fault, whatever its priority. Context codes are: 0 thread, 1 memory-management handler, 2 bus handler, 3 usage handler, 4 hard fault handler, 5 NMI handler, 6 and 7 any other exception.
- R4: Outside thread mode, a configurable fault escalates when its priority value is numerically equal to or greater than `cur_pri`; a lower value means more urgent, and ties do not preempt. A numerically lower value is taken as its own kind with preemption. In thread mode (context 0), an enabled fault never escalates on priority. In the hard fault handler and NMI handler contexts, configurable faults always escalate.
- R5: A bus fault with `req_stacking` high is taken as a bus fault, not escalated and preempting, regardless of priority, enable and context. For other kinds, `req_stacking` has no effect.
- R6: A hard fault, whether raised directly or by escalation, preempts in every context except the hard fault handler and the NMI handler. In those two contexts it does not preempt and the block enters lockup.
- R7: While locked, `locked` and `halt` are high. An `nmi` pulse releases a lockup entered from the hard fault handler context, with `locked` low after that edge. A lockup entered from the NMI handler context is not released by `nmi`; only reset releases it.
- R8: Status bits are sticky, one per kind: bit 0 memory-management, bit 1 bus, bit 2 usage, bit 3 hard. Bit 4 is the forced flag. A taken configurable fault sets its own bit. An escalation also sets bits 3 and 4. A direct hard fault sets bit 3 only.
- R9: `stat_clr_we` clears each status bit whose bit in `stat_clr_mask` is one. A bit that is set and cleared in the same cycle ends up set.
- R10: `en_we` loads `en_d` into the handler enables: bit 0 memory-management, bit 1 bus, bit 2 usage.
- R11: Reset clears lockup, all status bits, all handler enables and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Fault request offered |
| req_ready | output | 1 | Request can be accepted (low while locked) |
| req_kind | input | 2 | Fault kind: 0 mem, 1 bus, 2 usage, 3 hard |
| req_stacking | input | 1 | Fault happened during the stack push on entry to the bus fault handler |
| cur_ctx | input | 3 | Current execution context code |
| cur_pri | input | 3 | Current execution priority |
| pri_mem | input | 3 | Memory-management fault priority |
| pri_bus | input | 3 | Bus fault priority |
| pri_usage | input | 3 | Usage fault priority |
| en_we | input | 1 | Write strobe for handler enables |
| en_d | input | 3 | Handler enable write data |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 5 | Write-one-to-clear mask for status |
| nmi | input | 1 | NMI pulse |
| out_valid | output | 1 | Outcome pulse |
| out_kind | output | 2 | Fault kind taken |
| out_escalated | output | 1 | Outcome is an escalated hard fault |
| out_preempt | output | 1 | Chosen handler preempts current code |
| status | output | 5 | Sticky fault status bits |
| locked | output | 1 | Lockup state |
| halt | output | 1 | Instruction execution halted |

## Verification
The bench probes the priority tie, where a design that compares with strict inequality would let an equal-priority fault preempt instead of escalating. It checks a same-kind fault raised with a very urgent priority: a design that tests only priority would miss that escalation. It raises a bus fault during stacking from a context that would otherwise force escalation; a design without the exemption would report a forced hard fault. It sends an NMI into a lockup that began in the NMI handler, which a design with no record of the lockup's origin would wrongly release. It also clears a status bit in the same cycle that bit is set, which a design with clear priority would drop.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  localparam int PRI_W  = 3;
  localparam int STAT_W = 5;
  localparam int NCFG   = 3;

  typedef enum logic [1:0] {
    K_MEM   = 2'd0,
    K_BUS   = 2'd1,
    K_USAGE = 2'd2,
    K_HARD  = 2'd3
  } fkind_e;

  typedef enum logic [2:0] {
    C_THREAD = 3'd0,
    C_MEM    = 3'd1,
    C_BUS    = 3'd2,
    C_USAGE  = 3'd3,
    C_HARD   = 3'd4,
    C_NMI    = 3'd5,
    C_EXC6   = 3'd6,
    C_EXC7   = 3'd7
  } ctx_e;

  localparam int SB_HARD   = 3;
  localparam int SB_FORCED = 4;

  typedef struct packed {
    fkind_e            kind;
    logic              escalated;
    logic              preempt;
    logic              lock_enter;
    logic              lock_in_nmi;
    logic [STAT_W-1:0] set_mask;
  } verdict_t;
endpackage

// File: rtl/fault_esc_decide.sv
module fault_esc_decide
  import fault_esc_pkg::*;
#(
  parameter int PW = PRI_W
) (
  input  logic [1:0]      kind,
  input  logic            stacking,
  input  logic [2:0]      ctx,
  input  logic [PW-1:0]   cur_pri,
  input  logic [PW-1:0]   pri_mem,
  input  logic [PW-1:0]   pri_bus,
  input  logic [PW-1:0]   pri_usage,
  input  logic [NCFG-1:0] en,
  output verdict_t        verdict
);
  logic [PW-1:0] fpri;
  logic          cfg, same, fixed_ctx, stack_exempt, esc, hard;

  always_comb begin
    case (kind)
      K_MEM:   fpri = pri_mem;
      K_BUS:   fpri = pri_bus;
      default: fpri = pri_usage;
    endcase
  end

  assign cfg          = (kind != K_HARD);
  assign same         = cfg && (ctx == ({1'b0, kind} + 3'd1));
  assign fixed_ctx    = (ctx == C_HARD) || (ctx == C_NMI);
  assign stack_exempt = (kind == K_BUS) && stacking;

  always_comb begin
    esc = 1'b0;
    if (cfg && !stack_exempt) begin
      if (!en[kind])
        esc = 1'b1;
      else if (same || fixed_ctx)
        esc = 1'b1;
      else if ((ctx != C_THREAD) && (fpri >= cur_pri))
        esc = 1'b1;
    end
  end

  assign hard = !cfg || esc;

  always_comb begin
    verdict             = '0;
    verdict.kind        = hard ? K_HARD : fkind_e'(kind);
    verdict.escalated   = esc;
    verdict.lock_enter  = hard && fixed_ctx;
    verdict.lock_in_nmi = hard && (ctx == C_NMI);
    verdict.preempt     = !(hard && fixed_ctx);
    if (cfg)
      verdict.set_mask[kind] = 1'b1;
    if (hard)
      verdict.set_mask[SB_HARD] = 1'b1;
    if (esc)
      verdict.set_mask[SB_FORCED] = 1'b1;
  end
endmodule

// File: rtl/fault_esc_status.sv
module fault_esc_status
  import fault_esc_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_mask,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] bits
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bits[i] <= 1'b0;
      else if (set_en && set_mask[i])
        bits[i] <= 1'b1;
      else if (clr_en && clr_mask[i])
        bits[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_esc_lockup.sv
module fault_esc_lockup (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic enter_in_nmi,
  input  logic nmi,
  output logic locked,
  output logic from_nmi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      from_nmi <= 1'b0;
    end else if (!locked) begin
      if (enter) begin
        locked   <= 1'b1;
        from_nmi <= enter_in_nmi;
      end
    end else if (nmi && !from_nmi) begin
      locked   <= 1'b0;
      from_nmi <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_esc_ctrl.sv
module fault_esc_ctrl
  import fault_esc_pkg::*;
#(
  parameter int PW = PRI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_stacking,
  input  logic [2:0]        cur_ctx,
  input  logic [PW-1:0]     cur_pri,
  input  logic [PW-1:0]     pri_mem,
  input  logic [PW-1:0]     pri_bus,
  input  logic [PW-1:0]     pri_usage,
  input  logic              en_we,
  input  logic [NCFG-1:0]   en_d,
  input  logic              stat_clr_we,
  input  logic [STAT_W-1:0] stat_clr_mask,
  input  logic              nmi,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic              out_escalated,
  output logic              out_preempt,
  output logic [STAT_W-1:0] status,
  output logic              locked,
  output logic              halt
);
  logic [NCFG-1:0] en_q;
  logic            fire;
  logic            lock_from_nmi;
  verdict_t        vd;

  assign req_ready = !locked;
  assign fire      = req_valid && req_ready;
  assign halt      = locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (en_we)
      en_q <= en_d;
  end

  fault_esc_decide #(.PW(PW)) u_decide (
    .kind      (req_kind),
    .stacking  (req_stacking),
    .ctx       (cur_ctx),
    .cur_pri   (cur_pri),
    .pri_mem   (pri_mem),
    .pri_bus   (pri_bus),
    .pri_usage (pri_usage),
    .en        (en_q),
    .verdict   (vd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_kind      <= K_MEM;
      out_escalated <= 1'b0;
      out_preempt   <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_kind      <= vd.kind;
        out_escalated <= vd.escalated;
        out_preempt   <= vd.preempt;
      end
    end
  end

  fault_esc_status #(.W(STAT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (fire),
    .set_mask (vd.set_mask),
    .clr_en   (stat_clr_we),
    .clr_mask (stat_clr_mask),
    .bits     (status)
  );

  fault_esc_lockup u_lockup (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter        (fire && vd.lock_enter),
    .enter_in_nmi (vd.lock_in_nmi),
    .nmi          (nmi),
    .locked       (locked),
    .from_nmi     (lock_from_nmi)
  );
endmodule

// File: rtl/fault_esc_ctrl_chk.sv
module fault_esc_ctrl_chk
  import fault_esc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              req_stacking,
  input logic [2:0]        cur_ctx,
  input logic [2:0]        en_q,
  input logic              nmi,
  input logic              out_valid,
  input logic [1:0]        out_kind,
  input logic              out_escalated,
  input logic [STAT_W-1:0] status,
  input logic              locked,
  input logic              lock_from_nmi
);
  logic fire;
  assign fire = req_valid && req_ready;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  p_no_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !out_valid);
  p_disabled_esc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_kind != K_HARD && !en_q[req_kind] && !(req_kind == K_BUS && req_stacking))
    |=> (out_kind == K_HARD && out_escalated));
  p_stack_exempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_kind == K_BUS && req_stacking) |=> (out_kind == K_BUS && !out_escalated));
  p_thread_no_esc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cur_ctx == C_THREAD && req_kind != K_HARD && en_q[req_kind]) |=> !out_escalated);
  p_lock_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(fire) && out_kind == K_HARD));
  p_lock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(nmi) && !$past(lock_from_nmi)));
  p_forced_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_escalated) |-> (status[SB_HARD] && status[SB_FORCED]));
endmodule

bind fault_esc_ctrl fault_esc_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_kind      (req_kind),
  .req_stacking  (req_stacking),
  .cur_ctx       (cur_ctx),
  .en_q          (en_q),
  .nmi           (nmi),
  .out_valid     (out_valid),
  .out_kind      (out_kind),
  .out_escalated (out_escalated),
  .status        (status),
  .locked        (locked),
  .lock_from_nmi (lock_from_nmi)
);

// File: tb/fault_esc_ctrl_tb.sv
module fault_esc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic       req_stacking = 1'b0;
  logic [2:0] cur_ctx = '0, cur_pri = '0;
  logic [2:0] pri_mem = '0, pri_bus = '0, pri_usage = '0;
  logic       en_we = 1'b0;
  logic [2:0] en_d = '0;
  logic       stat_clr_we = 1'b0;
  logic [4:0] stat_clr_mask = '0;
  logic       nmi = 1'b0;
  logic       out_valid, out_escalated, out_preempt, locked, halt;
  logic [1:0] out_kind;
  logic [4:0] status;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fault_esc_ctrl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_en(input logic [2:0] v);
    @(negedge clk);
    en_we = 1'b1; en_d = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk);
    stat_clr_we = 1'b1; stat_clr_mask = 5'h1f;
    @(negedge clk);
    stat_clr_we = 1'b0;
  endtask

  // Offers one fault; outputs are checked at the negedge after the accepting edge.
  task automatic raise(input logic [1:0] k, input logic [2:0] ctx, input logic [2:0] cp,
                       input logic stk);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; cur_ctx = ctx; cur_pri = cp; req_stacking = stk;
    @(negedge clk);
    req_valid = 1'b0; req_stacking = 1'b0;
  endtask

  task automatic expect_out(input string req, input int kind, input int esc, input int pre);
    chk({req, " valid"}, out_valid, 1);
    chk({req, " kind"}, out_kind, kind);
    chk({req, " escalated"}, out_escalated, esc);
    chk({req, " preempt"}, out_preempt, pre);
  endtask

  task automatic t_reset();
    chk("R11 status", status, 0);
    chk("R11 locked", locked, 0);
    chk("R11 out_valid", out_valid, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_disabled();
    pri_mem = 3'd1; pri_bus = 3'd4; pri_usage = 3'd6;
    raise(2'd0, 3'd0, 3'd0, 1'b0);
    expect_out("R2", 3, 1, 1);
    chk("R8 escalated status", status, 5'h19);
    @(negedge clk);
    chk("R1 pulse", out_valid, 0);
    clr_all();
    chk("R9 clear all", status, 0);
  endtask

  task automatic t_thread();
    set_en(3'b111);
    raise(2'd0, 3'd0, 3'd0, 1'b0);
    expect_out("R4 thread", 0, 0, 1);
    chk("R8 mem bit", status, 5'h01);
    clr_all();
  endtask

  task automatic t_same_kind();
    pri_usage = 3'd0;
    raise(2'd2, 3'd3, 3'd7, 1'b0);
    expect_out("R3", 3, 1, 1);
    pri_usage = 3'd6;
    clr_all();
  endtask

  task automatic t_priority();
    pri_bus = 3'd3;
    raise(2'd1, 3'd6, 3'd3, 1'b0);
    expect_out("R4 tie", 3, 1, 1);
    pri_bus = 3'd2;
    raise(2'd1, 3'd6, 3'd3, 1'b0);
    expect_out("R4 higher", 1, 0, 1);
    pri_bus = 3'd5;
    raise(2'd1, 3'd6, 3'd3, 1'b0);
    expect_out("R4 lower", 3, 1, 1);
    clr_all();
  endtask

  task automatic t_stacking();
    pri_bus = 3'd7;
    raise(2'd1, 3'd2, 3'd0, 1'b1);
    expect_out("R5 stacking", 1, 0, 1);
    chk("R5 status", status, 5'h02);
    raise(2'd0, 3'd0, 3'd0, 1'b1);
    expect_out("R5 other kind", 0, 0, 1);
    clr_all();
  endtask

  task automatic t_lock_hard();
    raise(2'd3, 3'd6, 3'd0, 1'b0);
    expect_out("R6 direct hard", 3, 0, 1);
    raise(2'd3, 3'd4, 3'd0, 1'b0);
    expect_out("R6 lock", 3, 0, 0);
    chk("R7 locked", locked, 1);
    chk("R7 halt", halt, 1);
    chk("R1 not ready", req_ready, 0);
    clr_all();
    raise(2'd0, 3'd0, 3'd0, 1'b0);
    chk("R1 ignored valid", out_valid, 0);
    chk("R1 ignored status", status, 0);
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R7 nmi release", locked, 0);
  endtask

  task automatic t_lock_nmi();
    raise(2'd2, 3'd5, 3'd0, 1'b0);
    expect_out("R6 nmi ctx", 3, 1, 0);
    chk("R7 locked nmi", locked, 1);
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R7 nmi no release", locked, 1);
    do_reset();
    chk("R11 lock cleared", locked, 0);
    chk("R11 status cleared", status, 0);
    raise(2'd1, 3'd0, 3'd0, 1'b0);
    expect_out("R11 enables cleared", 3, 1, 1);
  endtask

  task automatic t_set_wins();
    clr_all();
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3; cur_ctx = 3'd0;
    stat_clr_we = 1'b1; stat_clr_mask = 5'h08;
    @(negedge clk);
    req_valid = 1'b0; stat_clr_we = 1'b0;
    chk("R9 set wins", status, 5'h08);
    set_en(3'b010);
    raise(2'd1, 3'd0, 3'd0, 1'b0);
    expect_out("R10 bus enabled", 1, 0, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_disabled();
    t_thread();
    t_same_kind();
    t_priority();
    t_stacking();
    t_lock_hard();
    t_lock_nmi();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule